// File: doc/BRIEF.md
# First-Error Capture Unit

This unit gathers error reports from the detectors of a host bridge and keeps a snapshot of the first error it sees. Five detectors feed it single-cycle strobes: memory read parity, secondary-cache data parity, out-of-range memory address, unsupported processor-bus cycle and ROM-space write. Each strobe carries the faulting address and, where it applies, whether a PCI master or the processor bus started the transaction. The unit folds the strobe into two 8-bit status registers and a shared address register.

Once a snapshot is held, further strobes are dropped until software has cleared every status bit, with write-one-to-clear, through a small register port. Reads are combinational. The detector strobes are fire-and-forget: there is no ready or back-pressure, and a strobe that arrives while the unit is frozen is lost. A level output tells the interrupt logic that a snapshot is pending.

Top module: `err_first_capture`

## Requirements
- R1: After reset, status register 1, status register 2 and the address register read zero and `err_irq` is low.
- R2: A memory read parity strobe sets status1 bit 2, copies the PCI-origin input into status1 bit 3, leaves status2 bit 7 (address invalid) at 0 and captures the address.
- R3: An out-of-range address strobe sets status2 bit 1, copies the PCI-origin input into status1 bit 3, leaves status2 bit 7 at 0 and captures the address.
- R4: A secondary-cache parity strobe sets status2 bit 2 and status2 bit 7, clears status1 bit 3 and loads zero into the address register.
- R5: A ROM-space write strobe sets status2 bit 0, clears status1 bit 3 and status2 bit 7, and captures the address.
- R6: An unsupported-cycle strobe writes its 2-bit kind (1 to 3) into status1 bits 1:0, clears the origin and address-invalid bits and captures the address. A kind of 0 is ignored.
- R7: While any bit of either status register is set, a new strobe changes neither status register nor the address register.
- R8: A write to register index 0 (status1) or 1 (status2) clears exactly the bits written as one. Writes to index 2 (address) or 3 have no effect.
- R9: Capture resumes only once both status registers are all zero. A clear that leaves any bit set keeps the unit frozen.
- R10: When a clear and a strobe land in the same cycle and the clear empties both status registers, the strobe is captured in that cycle.
- R11: `err_irq` is high exactly while any bit of either status register is set.
- R12: Of strobes arriving in the same cycle, only one is captured, in the order memory parity, cache parity, out-of-range, unsupported cycle, ROM write.
- R13: Read index 0 returns status1, index 1 returns status2 (both zero-extended), index 2 returns the address and index 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| memrd_par_vld | input | 1 | Memory read parity error strobe |
| memrd_par_pci | input | 1 | Memory read issued by a PCI master |
| memrd_par_addr | input | AW | Memory read address |
| l2_par_vld | input | 1 | Secondary-cache data parity error strobe |
| range_vld | input | 1 | Out-of-range memory address strobe |
| range_pci | input | 1 | Out-of-range access issued by a PCI master |
| range_addr | input | AW | Out-of-range address |
| unsup_vld | input | 1 | Unsupported processor-bus cycle strobe |
| unsup_kind | input | 2 | Unsupported cycle kind, 1 to 3 |
| unsup_addr | input | AW | Unsupported cycle address |
| rom_wr_vld | input | 1 | Illegal ROM-space write strobe |
| rom_wr_addr | input | AW | ROM write address |
| reg_addr | input | 2 | Register index for read and write |
| reg_wr | input | 1 | Write strobe, write-one-to-clear |
| reg_wdata | input | DW | Write data, low 8 bits used |
| reg_rdata | output | DW | Read data for `reg_addr` |
| err_irq | output | 1 | A snapshot is pending |

## Verification
The hardest case to reach from the ports is the cycle in which a clear and a fresh strobe coincide. The result depends on whether that one write empties both registers, including the origin and address-invalid qualifier bits that a careless handler leaves behind. The stimulus puts the write strobe and the detector strobe on the same falling edge. It does this once with a write that empties both registers and once with a write that leaves the origin bit set. A random phase then mixes strobes, stacked strobes and partial clears, and a behavioural model in the bench is compared against the outputs on every cycle.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int ST_W = 8;
  localparam int NUM_SRC = 5;

  // source indices, lower index wins when strobes coincide
  localparam int SRC_MEMRD = 0;
  localparam int SRC_L2    = 1;
  localparam int SRC_RANGE = 2;
  localparam int SRC_UNSUP = 3;
  localparam int SRC_ROM   = 4;

  // status register 1 fields
  localparam int S1_KIND_LO = 0;
  localparam int S1_MEMPAR  = 2;
  localparam int S1_PCI     = 3;
  // status register 2 fields
  localparam int S2_ROM     = 0;
  localparam int S2_RANGE   = 1;
  localparam int S2_L2      = 2;
  localparam int S2_AINV    = 7;

  typedef struct packed {
    logic            vld;
    logic [ST_W-1:0] s1;
    logic [ST_W-1:0] s2;
  } err_rec_t;
endpackage

// File: rtl/errcap_select.sv
module errcap_select
  import errcap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          memrd_par_vld,
  input  logic          memrd_par_pci,
  input  logic [AW-1:0] memrd_par_addr,
  input  logic          l2_par_vld,
  input  logic          range_vld,
  input  logic          range_pci,
  input  logic [AW-1:0] range_addr,
  input  logic          unsup_vld,
  input  logic [1:0]    unsup_kind,
  input  logic [AW-1:0] unsup_addr,
  input  logic          rom_wr_vld,
  input  logic [AW-1:0] rom_wr_addr,
  output err_rec_t      win_rec,
  output logic [AW-1:0] win_addr
);
  logic [NUM_SRC-1:0] cand_vld;
  logic [ST_W-1:0]    cand_s1   [NUM_SRC];
  logic [ST_W-1:0]    cand_s2   [NUM_SRC];
  logic [AW-1:0]      cand_addr [NUM_SRC];

  // each detector turns into a complete status record
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      cand_s1[i]   = '0;
      cand_s2[i]   = '0;
      cand_addr[i] = '0;
    end
    cand_vld = '0;

    cand_vld[SRC_MEMRD]            = memrd_par_vld;
    cand_s1[SRC_MEMRD][S1_MEMPAR]  = 1'b1;
    cand_s1[SRC_MEMRD][S1_PCI]     = memrd_par_pci;
    cand_addr[SRC_MEMRD]           = memrd_par_addr;

    cand_vld[SRC_L2]               = l2_par_vld;
    cand_s2[SRC_L2][S2_L2]         = 1'b1;
    cand_s2[SRC_L2][S2_AINV]       = 1'b1;

    cand_vld[SRC_RANGE]            = range_vld;
    cand_s2[SRC_RANGE][S2_RANGE]   = 1'b1;
    cand_s1[SRC_RANGE][S1_PCI]     = range_pci;
    cand_addr[SRC_RANGE]           = range_addr;

    cand_vld[SRC_UNSUP]                       = unsup_vld && (unsup_kind != 2'b00);
    cand_s1[SRC_UNSUP][S1_KIND_LO+1:S1_KIND_LO] = unsup_kind;
    cand_addr[SRC_UNSUP]                      = unsup_addr;

    cand_vld[SRC_ROM]              = rom_wr_vld;
    cand_s2[SRC_ROM][S2_ROM]       = 1'b1;
    cand_addr[SRC_ROM]             = rom_wr_addr;
  end

  // fixed priority: walk from lowest priority so the lowest index overwrites
  always_comb begin
    win_rec  = '0;
    win_addr = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand_vld[i]) begin
        win_rec.vld = 1'b1;
        win_rec.s1  = cand_s1[i];
        win_rec.s2  = cand_s2[i];
        win_addr    = cand_addr[i];
      end
    end
  end
endmodule

// File: rtl/errcap_regs.sv
module errcap_regs
  import errcap_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  err_rec_t        ev_rec,
  input  logic [AW-1:0]   ev_addr,
  input  logic            clr1_en,
  input  logic            clr2_en,
  input  logic [ST_W-1:0] clr_mask,
  output logic [ST_W-1:0] st1,
  output logic [ST_W-1:0] st2,
  output logic [AW-1:0]   cap_addr
);
  logic [ST_W-1:0] s1_left, s2_left;
  logic            armed;

  // clear is applied first; capture is allowed on what remains
  assign s1_left = clr1_en ? (st1 & ~clr_mask) : st1;
  assign s2_left = clr2_en ? (st2 & ~clr_mask) : st2;
  assign armed   = (s1_left == '0) && (s2_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1      <= '0;
      st2      <= '0;
      cap_addr <= '0;
    end else if (armed && ev_rec.vld) begin
      st1      <= ev_rec.s1;
      st2      <= ev_rec.s2;
      cap_addr <= ev_addr;
    end else begin
      st1      <= s1_left;
      st2      <= s2_left;
    end
  end

  // R7: frozen snapshot survives any strobe when no clear is written
  assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((st1 | st2) != '0) && !clr1_en && !clr2_en) |=> ($stable(st1) && $stable(st2) && $stable(cap_addr)));

  // R9: an empty register set with a strobe always ends up holding something
  assert_rearm_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (((st1 | st2) == '0) && ev_rec.vld) |=> ((st1 | st2) != '0));

  // R4: cache parity always comes with the address-invalid flag
  assert_l2_addr_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st2[S2_L2]) |-> (st2[S2_AINV] && !st1[S1_PCI] && cap_addr == '0));

  // R5: ROM write errors are processor-side with a valid address
  assert_rom_qualifiers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st2[S2_ROM]) |-> (!st1[S1_PCI] && !st2[S2_AINV]));

  // R12: at most one error type is ever recorded in a snapshot
  assert_single_type_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({(st1[S1_KIND_LO+1:S1_KIND_LO] != 2'b00), st1[S1_MEMPAR],
              st2[S2_ROM], st2[S2_RANGE], st2[S2_L2]}));
endmodule

// File: rtl/errcap_rdmux.sv
module errcap_rdmux
  import errcap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [1:0]      rd_idx,
  input  logic [ST_W-1:0] st1,
  input  logic [ST_W-1:0] st2,
  input  logic [AW-1:0]   cap_addr,
  output logic [DW-1:0]   rdata
);
  always_comb begin
    case (rd_idx)
      2'd0:    rdata = DW'(st1);
      2'd1:    rdata = DW'(st2);
      2'd2:    rdata = DW'(cap_addr);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/err_first_capture.sv
module err_first_capture
  import errcap_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          memrd_par_vld,
  input  logic          memrd_par_pci,
  input  logic [AW-1:0] memrd_par_addr,
  input  logic          l2_par_vld,
  input  logic          range_vld,
  input  logic          range_pci,
  input  logic [AW-1:0] range_addr,
  input  logic          unsup_vld,
  input  logic [1:0]    unsup_kind,
  input  logic [AW-1:0] unsup_addr,
  input  logic          rom_wr_vld,
  input  logic [AW-1:0] rom_wr_addr,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          err_irq
);
  localparam int IDX_ST1 = 0;
  localparam int IDX_ST2 = 1;

  err_rec_t        win_rec;
  logic [AW-1:0]   win_addr;
  logic [ST_W-1:0] st1, st2;
  logic [AW-1:0]   cap_addr;
  logic            clr1_en, clr2_en;

  assign clr1_en = reg_wr && (reg_addr == 2'(IDX_ST1));
  assign clr2_en = reg_wr && (reg_addr == 2'(IDX_ST2));

  errcap_select #(.AW(AW)) u_sel (
    .memrd_par_vld (memrd_par_vld),
    .memrd_par_pci (memrd_par_pci),
    .memrd_par_addr(memrd_par_addr),
    .l2_par_vld    (l2_par_vld),
    .range_vld     (range_vld),
    .range_pci     (range_pci),
    .range_addr    (range_addr),
    .unsup_vld     (unsup_vld),
    .unsup_kind    (unsup_kind),
    .unsup_addr    (unsup_addr),
    .rom_wr_vld    (rom_wr_vld),
    .rom_wr_addr   (rom_wr_addr),
    .win_rec       (win_rec),
    .win_addr      (win_addr)
  );

  errcap_regs #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_rec  (win_rec),
    .ev_addr (win_addr),
    .clr1_en (clr1_en),
    .clr2_en (clr2_en),
    .clr_mask(reg_wdata[ST_W-1:0]),
    .st1     (st1),
    .st2     (st2),
    .cap_addr(cap_addr)
  );

  errcap_rdmux #(.AW(AW), .DW(DW)) u_rd (
    .rd_idx  (reg_addr),
    .st1     (st1),
    .st2     (st2),
    .cap_addr(cap_addr),
    .rdata   (reg_rdata)
  );

  assign err_irq = (st1 != '0) || (st2 != '0);

  // R11: a pending snapshot cannot be dropped without a write to a status register
  assert_irq_needs_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_irq) && !err_irq) |-> $past(clr1_en || clr2_en));
endmodule

// File: tb/sim_err_first_capture.sv
`timescale 1ns/1ps
module sim_err_first_capture;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic memrd_par_vld = 0, memrd_par_pci = 0, l2_par_vld = 0;
  logic range_vld = 0, range_pci = 0, unsup_vld = 0, rom_wr_vld = 0;
  logic [AW-1:0] memrd_par_addr = 0, range_addr = 0, unsup_addr = 0, rom_wr_addr = 0;
  logic [1:0] unsup_kind = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata;
  logic err_irq;

  int n_run = 0, n_fail = 0;
  string cur_tag = "R1";
  bit done = 0;

  // behavioural model state
  logic [7:0] m1 = 0, m2 = 0;
  logic [31:0] ma = 0;

  always #2 clk = ~clk;

  err_first_capture #(.AW(AW), .DW(DW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge from the stable inputs
  always @(posedge clk) begin
    logic [7:0] c1, c2;
    if (rst_n) begin
      c1 = m1; c2 = m2;
      if (reg_wr && reg_addr == 2'd0) c1 = c1 & ~reg_wdata[7:0];
      if (reg_wr && reg_addr == 2'd1) c2 = c2 & ~reg_wdata[7:0];
      m1 = c1; m2 = c2;
      if (c1 == 0 && c2 == 0) begin
        if (memrd_par_vld) begin
          m1 = 8'h04 | (memrd_par_pci ? 8'h08 : 8'h00); m2 = 0; ma = memrd_par_addr;
        end else if (l2_par_vld) begin
          m1 = 0; m2 = 8'h84; ma = 0;
        end else if (range_vld) begin
          m1 = range_pci ? 8'h08 : 8'h00; m2 = 8'h02; ma = range_addr;
        end else if (unsup_vld && unsup_kind != 0) begin
          m1 = {6'b0, unsup_kind}; m2 = 0; ma = unsup_addr;
        end else if (rom_wr_vld) begin
          m1 = 0; m2 = 8'h01; ma = rom_wr_addr;
        end
      end
    end
  end

  // compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    logic [31:0] exp_rd;
    #1;
    if (rst_n && !done) begin
      case (reg_addr)
        2'd0: exp_rd = {24'b0, m1};
        2'd1: exp_rd = {24'b0, m2};
        2'd2: exp_rd = ma;
        default: exp_rd = 0;
      endcase
      chk(reg_rdata === exp_rd, cur_tag, reg_rdata, exp_rd);
      chk(err_irq === ((m1 | m2) != 0), "R11", {31'b0, err_irq}, {31'b0, ((m1 | m2) != 0)});
    end
  end

  task automatic quiet();
    memrd_par_vld = 0; l2_par_vld = 0; range_vld = 0; unsup_vld = 0; rom_wr_vld = 0;
    reg_wr = 0;
  endtask

  task automatic cyc(); @(negedge clk); quiet(); endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); quiet(); reg_addr = a; #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); quiet(); reg_wr = 1; reg_addr = a; reg_wdata = {24'b0, d};
    cyc();
  endtask

  task automatic ev_mem(input bit pci, input logic [31:0] a);
    @(negedge clk); quiet(); memrd_par_vld = 1; memrd_par_pci = pci; memrd_par_addr = a; cyc();
  endtask
  task automatic ev_l2();
    @(negedge clk); quiet(); l2_par_vld = 1; cyc();
  endtask
  task automatic ev_range(input bit pci, input logic [31:0] a);
    @(negedge clk); quiet(); range_vld = 1; range_pci = pci; range_addr = a; cyc();
  endtask
  task automatic ev_unsup(input logic [1:0] k, input logic [31:0] a);
    @(negedge clk); quiet(); unsup_vld = 1; unsup_kind = k; unsup_addr = a; cyc();
  endtask
  task automatic ev_rom(input logic [31:0] a);
    @(negedge clk); quiet(); rom_wr_vld = 1; rom_wr_addr = a; cyc();
  endtask

  task automatic clear_all(); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_tag = "R1";
    rd(0, 0, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1"); rd(3, 0, "R13");
    chk(err_irq === 1'b0, "R1", {31'b0, err_irq}, 0);

    cur_tag = "R2";
    ev_mem(1, 32'h1234_5678);
    rd(0, 32'h0C, "R2"); rd(1, 32'h00, "R2"); rd(2, 32'h1234_5678, "R2");
    chk(err_irq === 1'b1, "R11", {31'b0, err_irq}, 1);

    cur_tag = "R7";
    ev_rom(32'hAAAA_0000); ev_range(0, 32'h5555_0000); ev_l2();
    rd(0, 32'h0C, "R7"); rd(1, 0, "R7"); rd(2, 32'h1234_5678, "R7");

    cur_tag = "R9";
    wr(2'd0, 8'h04);
    rd(0, 32'h08, "R9");
    ev_rom(32'h0000_0BAD);
    rd(0, 32'h08, "R9"); rd(1, 0, "R9"); rd(2, 32'h1234_5678, "R9");
    cur_tag = "R8";
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); wr(2'd1, 8'hFF);
    rd(0, 32'h08, "R8"); rd(2, 32'h1234_5678, "R8");
    wr(2'd0, 8'h08);
    rd(0, 0, "R8");
    chk(err_irq === 1'b0, "R11", {31'b0, err_irq}, 0);

    cur_tag = "R5";
    ev_rom(32'hFFF0_0010);
    rd(0, 0, "R5"); rd(1, 32'h01, "R5"); rd(2, 32'hFFF0_0010, "R5");
    clear_all();

    cur_tag = "R4";
    ev_l2();
    rd(0, 0, "R4"); rd(1, 32'h84, "R4"); rd(2, 0, "R4");
    wr(2'd1, 8'h04);
    rd(1, 32'h80, "R9");
    wr(2'd1, 8'h80);

    cur_tag = "R3";
    ev_range(1, 32'h8000_0004);
    rd(0, 32'h08, "R3"); rd(1, 32'h02, "R3"); rd(2, 32'h8000_0004, "R3");
    clear_all();

    cur_tag = "R6";
    ev_unsup(2'd0, 32'h1111_1111);
    rd(0, 0, "R6"); rd(1, 0, "R6");
    ev_unsup(2'd2, 32'h2222_2222);
    rd(0, 32'h02, "R6"); rd(2, 32'h2222_2222, "R6");
    clear_all();
    ev_unsup(2'd3, 32'h3333_3333);
    rd(0, 32'h03, "R6");
    clear_all();

    cur_tag = "R12";
    @(negedge clk); quiet();
    memrd_par_vld = 1; memrd_par_pci = 0; memrd_par_addr = 32'hA0;
    l2_par_vld = 1; range_vld = 1; range_addr = 32'hA2; unsup_vld = 1; unsup_kind = 1;
    unsup_addr = 32'hA3; rom_wr_vld = 1; rom_wr_addr = 32'hA4;
    cyc();
    rd(0, 32'h04, "R12"); rd(2, 32'hA0, "R12");
    clear_all();
    @(negedge clk); quiet();
    l2_par_vld = 1; range_vld = 1; unsup_vld = 1; rom_wr_vld = 1; cyc();
    rd(1, 32'h84, "R12");
    clear_all();
    @(negedge clk); quiet();
    range_vld = 1; range_pci = 0; unsup_vld = 1; rom_wr_vld = 1; cyc();
    rd(1, 32'h02, "R12"); rd(2, 32'hA2, "R12");
    clear_all();
    @(negedge clk); quiet();
    unsup_vld = 1; rom_wr_vld = 1; cyc();
    rd(0, 32'h01, "R12"); rd(1, 0, "R12");
    clear_all();

    cur_tag = "R10";
    ev_rom(32'hC0);
    @(negedge clk); quiet();
    reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h01;
    range_vld = 1; range_pci = 0; range_addr = 32'hC1;
    cyc();
    rd(1, 32'h02, "R10"); rd(2, 32'hC1, "R10");
    clear_all();
    ev_mem(1, 32'hD0);
    @(negedge clk); quiet();
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h04; rom_wr_vld = 1; rom_wr_addr = 32'hD1;
    cyc();
    rd(0, 32'h08, "R10"); rd(1, 0, "R10"); rd(2, 32'hD0, "R10");
    clear_all();

    cur_tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); quiet();
      memrd_par_vld = ($urandom_range(0, 9) == 0);
      memrd_par_pci = $urandom_range(0, 1);
      memrd_par_addr = $urandom;
      l2_par_vld = ($urandom_range(0, 11) == 0);
      range_vld = ($urandom_range(0, 9) == 0);
      range_pci = $urandom_range(0, 1);
      range_addr = $urandom;
      unsup_vld = ($urandom_range(0, 7) == 0);
      unsup_kind = 2'($urandom_range(0, 3));
      unsup_addr = $urandom;
      rom_wr_vld = ($urandom_range(0, 7) == 0);
      rom_wr_addr = $urandom;
      reg_addr = 2'($urandom_range(0, 3));
      reg_wr = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom;
    end
    cyc();
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule